// File: doc/BRIEF.md
# Phase Shedding and Rotation Manager

This block chooses how many buck phases of a multi-phase regulator switch, and which ones. On each load-current strobe it compares the digital current against the add threshold and the drop threshold for the present phase count. It then moves the count up or down by one. The gap between the two threshold tables gives hysteresis, so the count does not oscillate at a boundary.

A load-step flag bypasses the threshold path and turns every healthy phase on at once. Shedding then stays frozen for a programmable number of samples.

While the count is below the maximum, the first phase of the active window moves one position at a fixed sample interval. Light-load duty is therefore spread across all phases. Any phase that reports overcurrent is left out of the active mask in the same cycle. If every phase reports overcurrent, a global fault output is raised. The mask drives the PWM generator directly.

Top module: `phase_shed_mgr`

## Requirements
- R1: After reset the count is 1, the window starts at phase 0, and `phase_en` is 0b0001 (bit i is phase i) with `all_fault` low.
- R2: On a strobe with count k < NPH and `load_i` >= add threshold k (field k-1 of `add_thr_i`, IW bits each, field 0 in the LSBs), the count becomes k+1 one clock later.
- R3: On a strobe with count k > 1, the count drops to k-1 only if `load_i` < drop threshold k (field k-2 of `drop_thr_i`). A load between the drop and add thresholds holds the count.
- R4: At most one phase is dropped per strobe. After a drop or a load step, the next `dwell_len` strobes cannot drop a phase.
- R5: A `load_step` pulse sets the count to NPH one clock later, whatever `load_i` is, and restarts the dwell window.
- R6: With count < NPH and `rot_interval` = N > 0, the window start advances by one phase, wrapping from NPH-1 to 0, on every Nth strobe. The mask holds the first `count` healthy phases, taken in circular order from the start.
- R7: The window start does not move while the count equals NPH, or while `rot_interval` is 0.
- R8: A phase whose `oc_flag` bit is set is never enabled. The exclusion takes effect in the same cycle as the flag.
- R9: While at least one phase is healthy, at least one phase is enabled. When all `oc_flag` bits are set, `all_fault` is high and `phase_en` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe marking a new current sample |
| load_i | input | IW | Load-current sample, unsigned |
| add_thr_i | input | (NPH-1)*IW | Add threshold per count; field k-1 applies at count k |
| drop_thr_i | input | (NPH-1)*IW | Drop threshold per count; field k-2 applies at count k |
| load_step | input | 1 | Fast transient request, enables all healthy phases |
| dwell_len | input | DW | Strobes that must pass before a phase may be dropped |
| rot_interval | input | RW | Strobes between window rotations; 0 disables rotation |
| oc_flag | input | NPH | Per-phase overcurrent indication |
| phase_en | output | NPH | Active-phase mask |
| all_fault | output | 1 | High when every phase is faulted |

## Verification
Count changes, dwell effects, load-step response and rotation are visible on `phase_en` one clock after the strobe or step cycle. The bench drives each strobe for one cycle from a falling edge and compares the mask at the next falling edge. Fault exclusion and `all_fault` follow `oc_flag` in the same cycle, so those checks are made one falling edge after `oc_flag` changes, with no strobe in between. The dwell and rotation checks count strobes and compare the mask on the exact strobe where the change is due, as well as on the strobe before it.

// File: rtl/phase_shed_mgr.sv
module phase_shed_mgr #(
  parameter int NPH = 4,
  parameter int IW  = 12,
  parameter int DW  = 8,
  parameter int RW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_valid,
  input  logic [IW-1:0]         load_i,
  input  logic [(NPH-1)*IW-1:0] add_thr_i,
  input  logic [(NPH-1)*IW-1:0] drop_thr_i,
  input  logic                  load_step,
  input  logic [DW-1:0]         dwell_len,
  input  logic [RW-1:0]         rot_interval,
  input  logic [NPH-1:0]        oc_flag,
  output logic [NPH-1:0]        phase_en,
  output logic                  all_fault
);
  localparam int CW = $clog2(NPH + 1);
  localparam int SW = (NPH > 1) ? $clog2(NPH) : 1;
  localparam logic [CW-1:0] CMAX = CW'(NPH);
  localparam logic [SW-1:0] SLAST = SW'(NPH - 1);

  logic [CW-1:0] cnt;
  logic [SW-1:0] st;
  logic [DW-1:0] dwl;
  logic [RW-1:0] rcnt;
  logic [IW-1:0] add_sel, drop_sel;
  logic          do_add, do_drop, rot_on, rot_hit;

  always_comb begin
    add_sel  = '0;
    drop_sel = '0;
    for (int k = 1; k < NPH; k++)
      if (cnt == CW'(k)) add_sel = add_thr_i[(k-1)*IW +: IW];
    for (int k = 2; k <= NPH; k++)
      if (cnt == CW'(k)) drop_sel = drop_thr_i[(k-2)*IW +: IW];
  end

  assign do_add  = sample_valid && (cnt < CMAX) && (load_i >= add_sel);
  assign do_drop = sample_valid && !do_add && (cnt > CW'(1)) && (dwl == '0) && (load_i < drop_sel);
  assign rot_on  = (cnt < CMAX) && (rot_interval != '0);
  assign rot_hit = rcnt >= (rot_interval - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= CW'(1);
      st   <= '0;
      dwl  <= '0;
      rcnt <= '0;
    end else if (load_step) begin
      cnt <= CMAX;
      dwl <= dwell_len;
    end else if (sample_valid) begin
      if (do_add)       cnt <= cnt + CW'(1);
      else if (do_drop) cnt <= cnt - CW'(1);
      if (do_drop)           dwl <= dwell_len;
      else if (dwl != '0)    dwl <= dwl - DW'(1);
      if (rot_on) begin
        if (rot_hit) begin
          st   <= (st == SLAST) ? '0 : st + SW'(1);
          rcnt <= '0;
        end else begin
          rcnt <= rcnt + RW'(1);
        end
      end else begin
        rcnt <= '0;
      end
    end
  end

  always_comb begin
    logic [CW-1:0] taken;
    logic [SW-1:0] pos;
    int            ii;
    phase_en = '0;
    taken    = '0;
    for (int o = 0; o < NPH; o++) begin
      ii = int'(st) + o;
      if (ii >= NPH) ii = ii - NPH;
      pos = SW'(ii);
      if (!oc_flag[pos] && (taken < cnt)) begin
        phase_en[pos] = 1'b1;
        taken         = taken + CW'(1);
      end
    end
  end

  assign all_fault = &oc_flag;

  p_step_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_step |=> (cnt == CMAX));

  p_drop_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && !load_step && dwl != '0) |=> (cnt >= $past(cnt)));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_step |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1))));

  p_hold_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !load_step) |=> $stable(st));

  p_fault_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_en & oc_flag) == '0);

  p_keep_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !all_fault |-> (phase_en != '0));

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CW'(1)) && (cnt <= CMAX));
endmodule

// File: tb/test_phase_shed_mgr.sv
`timescale 1ns/1ps
module test_phase_shed_mgr;
  localparam int NPH = 4, IW = 12, DW = 8, RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_valid = 1'b0;
  logic [IW-1:0] load_i = '0;
  logic [(NPH-1)*IW-1:0] add_thr_i = {12'd300, 12'd200, 12'd100};
  logic [(NPH-1)*IW-1:0] drop_thr_i = {12'd280, 12'd180, 12'd80};
  logic load_step = 1'b0;
  logic [DW-1:0] dwell_len = 8'd2;
  logic [RW-1:0] rot_interval = '0;
  logic [NPH-1:0] oc_flag = '0;
  logic [NPH-1:0] phase_en;
  logic all_fault;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phase_shed_mgr #(.NPH(NPH), .IW(IW), .DW(DW), .RW(RW)) i_phase_shed_mgr (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .load_i(load_i),
    .add_thr_i(add_thr_i), .drop_thr_i(drop_thr_i), .load_step(load_step),
    .dwell_len(dwell_len), .rot_interval(rot_interval), .oc_flag(oc_flag),
    .phase_en(phase_en), .all_fault(all_fault));

  // {step, load, expected mask}
  localparam logic [16:0] VEC [0:18] = '{
    {1'b0, 12'd50,  4'b0001}, {1'b0, 12'd100, 4'b0011}, {1'b0, 12'd150, 4'b0011},
    {1'b0, 12'd90,  4'b0011}, {1'b0, 12'd250, 4'b0111}, {1'b0, 12'd350, 4'b1111},
    {1'b0, 12'd500, 4'b1111}, {1'b0, 12'd270, 4'b0111}, {1'b0, 12'd10,  4'b0111},
    {1'b0, 12'd10,  4'b0111}, {1'b0, 12'd10,  4'b0011}, {1'b0, 12'd10,  4'b0011},
    {1'b0, 12'd10,  4'b0011}, {1'b0, 12'd10,  4'b0001}, {1'b0, 12'd10,  4'b0001},
    {1'b1, 12'd10,  4'b1111}, {1'b0, 12'd10,  4'b1111}, {1'b0, 12'd10,  4'b1111},
    {1'b0, 12'd10,  4'b0111}};

  task automatic check(string req, logic [NPH:0] act, logic [NPH:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic strobe(logic [IW-1:0] ld);
    @(negedge clk);
    load_i = ld;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    load_step = 1'b1;
    @(negedge clk);
    load_step = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset mask/fault", {all_fault, phase_en}, 5'b0_0001);

    for (int v = 0; v < 19; v++) begin
      if (VEC[v][16]) step();
      else strobe(VEC[v][15:4]);
      check($sformatf("R2 R3 R4 R5 vector %0d", v), {1'b0, phase_en}, {1'b0, VEC[v][3:0]});
    end

    // R6: rotation every third strobe at count 1
    do_reset();
    rot_interval = 16'd3;
    strobe(12'd50);
    strobe(12'd50);
    check("R6 no advance before interval", {1'b0, phase_en}, 5'b0_0001);
    strobe(12'd50);
    check("R6 advance to phase 1", {1'b0, phase_en}, 5'b0_0010);
    repeat (3) strobe(12'd50);
    check("R6 advance to phase 2", {1'b0, phase_en}, 5'b0_0100);
    repeat (3) strobe(12'd50);
    check("R6 advance to phase 3", {1'b0, phase_en}, 5'b0_1000);
    repeat (3) strobe(12'd50);
    check("R6 wrap to phase 0", {1'b0, phase_en}, 5'b0_0001);

    // R8: fault on the window start moves service to next healthy phase
    oc_flag = 4'b0001;
    @(negedge clk);
    check("R8 faulted phase excluded", {all_fault, phase_en}, 5'b0_0010);

    // R7: no rotation at full count
    rot_interval = 16'd1;
    step();
    check("R5 step with phase 0 faulted", {1'b0, phase_en}, 5'b0_1110);
    repeat (3) strobe(12'd500);
    oc_flag = 4'b0000;
    @(negedge clk);
    check("R8 cleared fault returns phase", {1'b0, phase_en}, 5'b0_1111);
    rot_interval = 16'd0;
    strobe(12'd10);
    check("R7 start held at full count", {1'b0, phase_en}, 5'b0_0111);
    repeat (4) strobe(12'd250);
    check("R7 interval zero holds start", {1'b0, phase_en}, 5'b0_0111);

    // R9: all faulted, then one survivor
    oc_flag = 4'b1111;
    @(negedge clk);
    check("R9 all faulted", {all_fault, phase_en}, 5'b1_0000);
    oc_flag = 4'b1110;
    @(negedge clk);
    check("R9 single survivor kept", {all_fault, phase_en}, 5'b0_0001);
    oc_flag = 4'b0000;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule